// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous graphics DRAM command bus. On every rising clock edge it samples the active-low chip select, the three active-low command strobes (row strobe, column strobe, write enable), a 3-bit bank address and a 12-bit address bus. It sorts the result into one command class. It tracks, for each of eight banks, whether a row is open and which row that is. When a column access is legal it reports the assembled column address together with the row being accessed.

Accesses that break the bank protocol raise a one-cycle error pulse and leave the bank state untouched. Such accesses are a column access to a closed bank, an activate to a bank that is already open, and a refresh while any bank is open. Mode register loads produce a write strobe for either the main or the extended register, together with the opcode. All outputs are registered. A command sampled at clock edge k is visible from edge k onward, until edge k+1. The interface carries no data stream, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `dram_cmd_tracker`

## Requirements
- R1: When chip select is sampled high, the command class is deselect (0). The bank address output is 0. No access, error or mode strobe occurs, and the open-bank mask is unchanged.
- R2: With chip select low, the strobes {row, column, write} select the class: L,H,H activate (2); H,L,H read (3); H,L,L write (4); L,H,L precharge (5); L,L,L mode load (6); L,L,H refresh (7); every other combination is no-operation (1). The class and the bank address appear on the outputs after the sampling edge.
- R3: An activate to a closed bank opens that bank and stores A11..A0 as its row. The matching bit of the 8-bit open mask (bit n is bank n) is set after the same edge.
- R4: A read or write to an open bank pulses the read or write strobe for one cycle. It outputs the 9-bit column {A9, A7..A0} and the stored row of that bank.
- R5: Address bit A8 on a legal read or write is reported as the auto-precharge flag, and the bank closes after the access.
- R6: A precharge with A8 low closes only the addressed bank; with A8 high it closes all eight banks.
- R7: A read or write to a closed bank gives a one-cycle error pulse. There is no access strobe, the column, row and flag outputs are zero, and the bank state is unchanged.
- R8: An activate to an open bank gives an error pulse and leaves the stored row unchanged.
- R9: A refresh gives an error pulse if any bank is open; with all banks closed it gives none.
- R10: A mode load with bank address 0 pulses the main-register strobe; with bank address 1 it pulses the extended-register strobe. The opcode output carries A11..A0 while either strobe is high and is zero otherwise. Any other bank address gives no strobe.
- R11: During and right after reset all banks are closed and every output is zero (class deselect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 12 | Row, column, flag or opcode bits |
| cmd_class_o | output | 3 | Registered command class |
| bank_o | output | 3 | Registered bank address, 0 on deselect |
| err_o | output | 1 | One-cycle protocol error pulse |
| acc_rd_o | output | 1 | Legal read strobe |
| acc_wr_o | output | 1 | Legal write strobe |
| col_o | output | 9 | Column of a legal access |
| auto_pre_o | output | 1 | Auto-precharge flag of a legal access |
| acc_row_o | output | 12 | Open row of the accessed bank |
| open_mask_o | output | 8 | Open flag per bank |
| mr_main_we_o | output | 1 | Main mode register write strobe |
| mr_ext_we_o | output | 1 | Extended mode register write strobe |
| mr_op_o | output | 12 | Mode register opcode |

## Verification
A wrong open flag shows up immediately in the open mask. It also changes how the next access to that bank is judged: an access that should be legal raises an error, or the reverse, in the cycle after that command. A corrupted row register stays hidden until the next legal read or write to the bank, and then appears as a wrong value on the accessed-row output. The bench therefore closes every sweep with reads to every open bank, so that stored rows are checked within a few cycles.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [2:0] {
    CMD_DES = 3'd0,
    CMD_NOP = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5,
    CMD_MRS = 3'd6,
    CMD_REF = 3'd7
  } cmd_e;
endpackage

// File: rtl/dct_cmd_decode.sv
module dct_cmd_decode
  import dct_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DES;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dct_bank_slot.sv
module dct_bank_slot #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else begin
      if (load_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
      end else if (close_i) begin
        open_o <= 1'b0;
      end
    end
  end

  // R3: a bank only becomes open through an activate
  assert_open_needs_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(load_i));

  // R8: the stored row of an open bank never moves
  assert_row_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && $past(open_o)) |-> $stable(row_o));
endmodule

// File: rtl/dct_mode_strobe.sv
module dct_mode_strobe #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              main_o,
  output logic              ext_o,
  output logic [ADDR_W-1:0] op_o
);
  localparam logic [BANK_W-1:0] SEL_MAIN = BANK_W'(0);
  localparam logic [BANK_W-1:0] SEL_EXT  = BANK_W'(1);

  logic hit_main, hit_ext;
  assign hit_main = mrs_i && (ba_i == SEL_MAIN);
  assign hit_ext  = mrs_i && (ba_i == SEL_EXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_o <= 1'b0;
      ext_o  <= 1'b0;
      op_o   <= '0;
    end else begin
      main_o <= hit_main;
      ext_o  <= hit_ext;
      op_o   <= (hit_main || hit_ext) ? addr_i : '0;
    end
  end

  // R10: never both registers at once
  assert_one_register_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_o && ext_o));

  // R10: a strobe always follows a mode load command
  assert_strobe_from_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (main_o || ext_o) |-> $past(mrs_i));
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [2:0]        cmd_class_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              err_o,
  output logic              acc_rd_o,
  output logic              acc_wr_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic [ROW_W-1:0]  acc_row_o,
  output logic [(1<<BANK_W)-1:0] open_mask_o,
  output logic              mr_main_we_o,
  output logic              mr_ext_we_o,
  output logic [ROW_W-1:0]  mr_op_o
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int HI_COL = COL_W - AP_BIT;

  cmd_e cmd;
  logic [NBANK-1:0] open_vec;
  logic [ROW_W-1:0] row_vec [NBANK];
  logic [NBANK-1:0] load_vec, close_vec;
  logic sel_open, is_acc, legal_acc, err_d, ap_flag;
  logic [COL_W-1:0] col_d;

  dct_cmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign sel_open  = open_vec[ba];
  assign is_acc    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign legal_acc = is_acc && sel_open;
  assign ap_flag   = addr[AP_BIT];
  assign col_d     = {addr[AP_BIT+1 +: HI_COL], addr[AP_BIT-1:0]};
  assign err_d     = (is_acc && !sel_open)
                   || ((cmd == CMD_ACT) && sel_open)
                   || ((cmd == CMD_REF) && (|open_vec));

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = (ba == BANK_W'(i));
    assign load_vec[i]  = (cmd == CMD_ACT) && hit && !open_vec[i];
    assign close_vec[i] = ((cmd == CMD_PRE) && (ap_flag || hit))
                        || (legal_acc && ap_flag && hit);

    dct_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_vec[i]),
      .close_i (close_vec[i]),
      .row_i   (addr),
      .open_o  (open_vec[i]),
      .row_o   (row_vec[i])
    );
  end

  dct_mode_strobe #(.ADDR_W(ROW_W), .BANK_W(BANK_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mrs_i  (cmd == CMD_MRS),
    .ba_i   (ba),
    .addr_i (addr),
    .main_o (mr_main_we_o),
    .ext_o  (mr_ext_we_o),
    .op_o   (mr_op_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_class_o <= CMD_DES;
      bank_o      <= '0;
      err_o       <= 1'b0;
      acc_rd_o    <= 1'b0;
      acc_wr_o    <= 1'b0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      acc_row_o   <= '0;
    end else begin
      cmd_class_o <= cmd;
      bank_o      <= (cmd == CMD_DES) ? '0 : ba;
      err_o       <= err_d;
      acc_rd_o    <= legal_acc && (cmd == CMD_RD);
      acc_wr_o    <= legal_acc && (cmd == CMD_WR);
      col_o       <= legal_acc ? col_d : '0;
      auto_pre_o  <= legal_acc && ap_flag;
      acc_row_o   <= legal_acc ? row_vec[ba] : '0;
    end
  end

  assign open_mask_o = open_vec;

  // R1: a deselected cycle produces no activity
  assert_quiet_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !(acc_rd_o || acc_wr_o || err_o || mr_main_we_o || mr_ext_we_o));

  // R7: an access strobe requires the bank to have been open
  assert_access_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_o || acc_wr_o) |-> $past(open_vec[ba]));

  // R9: an accepted refresh saw every bank closed
  assert_refresh_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_class_o == CMD_REF) && !err_o) |-> ($past(open_vec) == '0));

  // R4: read and write strobes never coincide
  assert_single_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd_o && acc_wr_o));
endmodule

// File: tb/dram_cmd_tracker_bench.sv
module dram_cmd_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [11:0] addr = '0;

  logic [2:0]  cmd_class_o, bank_o;
  logic        err_o, acc_rd_o, acc_wr_o, auto_pre_o, mr_main_we_o, mr_ext_we_o;
  logic [8:0]  col_o;
  logic [11:0] acc_row_o, mr_op_o;
  logic [7:0]  open_mask_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0]  m_open = '0;
  logic [11:0] m_row [8];

  always #2.5 clk = ~clk;

  dram_cmd_tracker u_dram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_class_o(cmd_class_o),
    .bank_o(bank_o), .err_o(err_o), .acc_rd_o(acc_rd_o), .acc_wr_o(acc_wr_o),
    .col_o(col_o), .auto_pre_o(auto_pre_o), .acc_row_o(acc_row_o),
    .open_mask_o(open_mask_o), .mr_main_we_o(mr_main_we_o),
    .mr_ext_we_o(mr_ext_we_o), .mr_op_o(mr_op_o)
  );

  function automatic logic [52:0] observed();
    return {cmd_class_o, err_o, acc_rd_o, acc_wr_o, bank_o, col_o, auto_pre_o,
            acc_row_o, open_mask_o, mr_main_we_o, mr_ext_we_o, mr_op_o};
  endfunction

  // Called at a falling edge: drives one command, predicts, checks at next falling edge
  task automatic send(input logic c, input logic r, input logic ca, input logic w,
                      input logic [2:0] b, input logic [11:0] a, input string tag);
    logic [2:0] cls;
    logic legal, e_err, e_rd, e_wr, e_ap, e_main, e_ext;
    logic [8:0] e_col;
    logic [11:0] e_row, e_op;
    logic [2:0] e_bank;
    logic [52:0] exp_v;
    logic [52:0] got_v;
    if (c) cls = 3'd0;
    else begin
      case ({r, ca, w})
        3'b011:  cls = 3'd2;
        3'b101:  cls = 3'd3;
        3'b100:  cls = 3'd4;
        3'b010:  cls = 3'd5;
        3'b000:  cls = 3'd6;
        3'b001:  cls = 3'd7;
        default: cls = 3'd1;
      endcase
    end
    legal  = ((cls == 3'd3) || (cls == 3'd4)) && m_open[b];
    e_err  = (((cls == 3'd3) || (cls == 3'd4)) && !m_open[b])
           || ((cls == 3'd2) && m_open[b]) || ((cls == 3'd7) && (m_open != 8'h00));
    e_rd   = legal && (cls == 3'd3);
    e_wr   = legal && (cls == 3'd4);
    e_col  = legal ? {a[9], a[7:0]} : 9'd0;
    e_ap   = legal ? a[8] : 1'b0;
    e_row  = legal ? m_row[b] : 12'd0;
    e_bank = c ? 3'd0 : b;
    e_main = (cls == 3'd6) && (b == 3'd0);
    e_ext  = (cls == 3'd6) && (b == 3'd1);
    e_op   = (e_main || e_ext) ? a : 12'd0;
    if ((cls == 3'd2) && !m_open[b]) begin
      m_open[b] = 1'b1;
      m_row[b]  = a;
    end
    if (cls == 3'd5) begin
      if (a[8]) m_open = 8'h00;
      else m_open[b] = 1'b0;
    end
    if (legal && a[8]) m_open[b] = 1'b0;
    exp_v = {cls, e_err, e_rd, e_wr, e_bank, e_col, e_ap, e_row, m_open, e_main, e_ext, e_op};
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
    got_v = observed();
    n_checks++;
    if (got_v !== exp_v) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h (cls %0d bank %0d addr %h)",
               tag, got_v, exp_v, cls, b, a);
    end
  endtask

  task automatic act(input logic [2:0] b, input logic [11:0] a, input string tag);
    send(1'b0, 1'b0, 1'b1, 1'b1, b, a, tag);
  endtask
  task automatic rd(input logic [2:0] b, input logic [11:0] a, input string tag);
    send(1'b0, 1'b1, 1'b0, 1'b1, b, a, tag);
  endtask
  task automatic wr(input logic [2:0] b, input logic [11:0] a, input string tag);
    send(1'b0, 1'b1, 1'b0, 1'b0, b, a, tag);
  endtask
  task automatic pre(input logic [2:0] b, input logic all, input string tag);
    send(1'b0, 1'b0, 1'b1, 1'b0, b, all ? 12'h100 : 12'h000, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_row[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state while held in reset
    n_checks++;
    if (observed() !== 53'd0) begin
      n_errors++;
      $display("FAIL R11: got %h expected %h", observed(), 53'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (observed() !== 53'd0) begin
      n_errors++;
      $display("FAIL R11: got %h expected %h", observed(), 53'd0);
    end

    // R2: every strobe combination with chip select low and high, every bank
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 8; b++) begin
        send(p[3], p[2], p[1], p[0], 3'(b), 12'((p * 37 + b * 291) & 12'hfff), "R2");
      end
    end
    pre(3'd0, 1'b1, "R6");

    // R3: open every bank with a distinct row
    for (int b = 0; b < 8; b++) act(3'(b), 12'(12'h0A0 + b * 413), "R3");
    // R4: column sweep over each bank, both A9 values, A8 low
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 8; k++) begin
        rd(3'(b), 12'({k[0], 1'b0, 8'(k * 33 + b)}), "R4");
        wr(3'(b), 12'({k[1], 1'b0, 8'(255 - k * 17)}), "R4");
      end
    end
    // R8: activate to open banks keeps the rows; read back to confirm
    for (int b = 0; b < 8; b++) act(3'(b), 12'hFFF, "R8");
    for (int b = 0; b < 8; b++) rd(3'(b), 12'h055, "R8");
    // R9: refresh with banks open
    send(1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 12'h000, "R9");
    // R1: deselect with active-looking strobes changes nothing
    for (int p = 0; p < 8; p++) send(1'b1, p[2], p[1], p[0], 3'(p), 12'h100, "R1");
    // R5: auto-precharge read and write, then access the closed bank
    rd(3'd3, 12'h3A5, "R5");
    rd(3'd3, 12'h0A5, "R7");
    wr(3'd5, 12'h1FF, "R5");
    wr(3'd5, 12'h0FF, "R7");
    // R6: single-bank precharge leaves others open
    pre(3'd0, 1'b0, "R6");
    rd(3'd0, 12'h001, "R7");
    rd(3'd1, 12'h002, "R6");
    pre(3'd6, 1'b1, "R6");
    for (int b = 0; b < 8; b++) rd(3'(b), 12'h010, "R7");
    // R9: refresh with all banks closed
    send(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 12'h000, "R9");
    // R10: mode load for every bank address
    for (int b = 0; b < 8; b++) send(1'b0, 1'b0, 1'b0, 1'b0, 3'(b), 12'(12'h321 + b * 257), "R10");
    // R3 + R4: reopen with new rows after closing
    for (int b = 0; b < 8; b++) act(3'(b), 12'(12'hF00 - b * 99), "R3");
    for (int b = 0; b < 8; b++) wr(3'(b), 12'h2C3, "R4");
    send(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 12'h000, "R1");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule